// File: doc/BRIEF.md
# Packed Integer Dot-Product Unit

This block is one slice of a vector ALU. For every lane it treats two 32-bit source words as packed vectors of small integers, multiplies the matching elements, adds the products together with a 32-bit accumulator operand, and registers the 32-bit sum. Three element widths (16, 8 and 4 bits) are available, each in a signed and an unsigned flavour. An optional clamp limits every individual product before it is summed.

Before the multiply, each working source word is put together from the 16-bit halves of its raw operand. A shared half-select control chooses these halves, so one instruction can reuse either half of a register in either position. An execution mask gates each lane. A lane that is masked off keeps the value it last registered. Results appear one clock after the valid strobe that carried the inputs.

Top module: `pk_dot_unit`

## Requirements
- R1: `mode[2:1]` selects the element width: 00 gives two 16-bit elements, 01 gives four 8-bit elements and 10 gives eight 4-bit elements. `mode[0]`=1 selects unsigned and 0 selects signed. With element width N, element i of a working word sits at bits [i*N+N-1 : i*N].
- R2: In a signed mode, each element of both words is sign-extended before the multiply. If `clamp_en` is set, the product is first limited to [-(2^(N-1)), 2^(N-1)-1]. The product is then always cut to its low N bits and sign-extended back to 32 bits before it is added.
- R3: In an unsigned mode, elements are zero-extended. If `clamp_en` is set, each product is limited to [0, 2^N-1]. Without the clamp, the full 32-bit product is added with no cut to N bits.
- R4: The lane result is the sum of all element products plus the lane's `src_c` word. All additions are modulo 2^32.
- R5: The low 16 bits of working word A come from the upper half of raw A when `opsel[0]`=1 and from the lower half when it is 0. The high 16 bits of working word A are chosen the same way by `opsel_hi[0]`.
- R6: Working word B is built the same way using `opsel[1]` and `opsel_hi[1]`. `opsel[2]` and `opsel_hi[2]` have no effect on any result.
- R7: A lane whose `exec_mask` bit is 0 keeps its previous `result` value. All lanes keep their values in a cycle where `in_valid` is 0.
- R8: `out_valid` is 1 in exactly the cycle after `in_valid` was sampled 1. The updated results are visible in that same cycle.
- R9: A mode with `mode[2:1]`=11 is illegal. Every enabled lane then registers zero, and `out_illegal` is 1 for that single result cycle, together with `out_valid`.
- R10: Reset clears `out_valid`, `out_illegal` and every lane result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are sampled on this cycle |
| mode | input | 3 | Element width and signedness (R1) |
| clamp_en | input | 1 | Per-product clamp enable |
| opsel | input | 3 | Half select for the low halves of the working words |
| opsel_hi | input | 3 | Half select for the high halves of the working words |
| exec_mask | input | LANES | Per-lane write enable |
| src_a | input | 32*LANES | Raw operand A, lane l at bits [32l+31:32l] |
| src_b | input | 32*LANES | Raw operand B, same packing as src_a |
| src_c | input | 32*LANES | Accumulator operand, same packing as src_a |
| out_valid | output | 1 | Result cycle strobe |
| out_illegal | output | 1 | The result cycle came from an illegal mode |
| result | output | 32*LANES | Registered per-lane results |

## Verification
The hardest situations to reach are the ones where a product wraps inside its element. Examples are a signed product that overflows N bits without the clamp, and an unsigned 16-bit product close to 2^32 whose sum then wraps past the accumulator. Random operands rarely produce these. Directed words built from all-ones and the most negative element values force them. These are mixed with back-to-back strobes whose lane masks change, so a held lane sits next to lanes being written in the same cycle.

// File: rtl/pk_dot_pkg.sv
package pk_dot_pkg;
   localparam int WORD_W = 32;
   localparam int HALF_W = WORD_W / 2;

   typedef enum logic [1:0] {
      ESZ_16  = 2'b00,
      ESZ_8   = 2'b01,
      ESZ_4   = 2'b10,
      ESZ_BAD = 2'b11
   } elem_size_e;

   function automatic logic size_is_bad(input logic [1:0] sz);
      return sz == ESZ_BAD;
   endfunction
endpackage

// File: rtl/pk_dot_opsel.sv
module pk_dot_opsel
   import pk_dot_pkg::*;
(
   input  logic [WORD_W-1:0] raw,
   input  logic              sel_lo,
   input  logic              sel_hi,
   output logic [WORD_W-1:0] word
);
   logic [HALF_W-1:0] upper_half;
   logic [HALF_W-1:0] lower_half;

   assign upper_half = raw[WORD_W-1:HALF_W];
   assign lower_half = raw[HALF_W-1:0];

   // each half of the working word picks either raw half independently
   assign word = {(sel_hi ? upper_half : lower_half),
                  (sel_lo ? upper_half : lower_half)};
endmodule

// File: rtl/pk_dot_group.sv
module pk_dot_group
   import pk_dot_pkg::*;
#(
   parameter int EW = 8
) (
   input  logic [WORD_W-1:0] a_word,
   input  logic [WORD_W-1:0] b_word,
   input  logic              signed_mode,
   input  logic              clamp,
   output logic [WORD_W-1:0] psum
);
   localparam int CNT    = WORD_W / EW;
   localparam int SMAX_I = (1 << (EW - 1)) - 1;
   localparam int SMIN_I = -(1 << (EW - 1));
   localparam logic [WORD_W-1:0] UMAX = WORD_W'((64'd1 << EW) - 64'd1);

   if (EW < 2 || EW > HALF_W || (WORD_W % EW) != 0) begin : g_bad_ew
      $error("pk_dot_group: EW must divide the word and be 2..16");
   end

   logic [CNT*WORD_W-1:0] terms;

   for (genvar e = 0; e < CNT; e++) begin : g_elem
      logic [EW-1:0]     ea, eb;
      logic [WORD_W-1:0] xa, xb;
      logic [WORD_W-1:0] prod;
      logic [WORD_W-1:0] lim;

      assign ea = a_word[e*EW +: EW];
      assign eb = b_word[e*EW +: EW];
      assign xa = signed_mode ? {{(WORD_W-EW){ea[EW-1]}}, ea}
                              : {{(WORD_W-EW){1'b0}}, ea};
      assign xb = signed_mode ? {{(WORD_W-EW){eb[EW-1]}}, eb}
                              : {{(WORD_W-EW){1'b0}}, eb};
      assign prod = xa * xb;

      always_comb begin
         lim = prod;
         if (signed_mode) begin
            if (clamp) begin
               if ($signed(prod) > SMAX_I)      lim = SMAX_I;
               else if ($signed(prod) < SMIN_I) lim = SMIN_I;
            end
         end else if (clamp && (prod > UMAX)) begin
            lim = UMAX;
         end
      end

      // signed terms are always folded to EW bits, unsigned never are
      assign terms[e*WORD_W +: WORD_W] =
         signed_mode ? {{(WORD_W-EW){lim[EW-1]}}, lim[EW-1:0]} : lim;
   end

   always_comb begin
      psum = '0;
      for (int i = 0; i < CNT; i++) begin
         psum = psum + terms[i*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/pk_dot_lane.sv
module pk_dot_lane
   import pk_dot_pkg::*;
(
   input  logic [WORD_W-1:0] raw_a,
   input  logic [WORD_W-1:0] raw_b,
   input  logic [WORD_W-1:0] acc,
   input  logic [1:0]        size_sel,
   input  logic              uns,
   input  logic              clamp,
   input  logic              sa_lo,
   input  logic              sa_hi,
   input  logic              sb_lo,
   input  logic              sb_hi,
   output logic [WORD_W-1:0] dot
);
   localparam int NSIZES = 3;

   logic [WORD_W-1:0]        wa, wb;
   logic [NSIZES*WORD_W-1:0] grp;

   pk_dot_opsel u_sel_a (.raw(raw_a), .sel_lo(sa_lo), .sel_hi(sa_hi), .word(wa));
   pk_dot_opsel u_sel_b (.raw(raw_b), .sel_lo(sb_lo), .sel_hi(sb_hi), .word(wb));

   // one reduction tree per element width: 16, 8, 4
   for (genvar k = 0; k < NSIZES; k++) begin : g_size
      localparam int EWK = HALF_W >> k;
      pk_dot_group #(.EW(EWK)) u_grp (
         .a_word      (wa),
         .b_word      (wb),
         .signed_mode (!uns),
         .clamp       (clamp),
         .psum        (grp[k*WORD_W +: WORD_W])
      );
   end

   always_comb begin
      unique case (elem_size_e'(size_sel))
         ESZ_16:  dot = grp[0*WORD_W +: WORD_W] + acc;
         ESZ_8:   dot = grp[1*WORD_W +: WORD_W] + acc;
         ESZ_4:   dot = grp[2*WORD_W +: WORD_W] + acc;
         default: dot = '0;
      endcase
   end
endmodule

// File: rtl/pk_dot_unit.sv
module pk_dot_unit
   import pk_dot_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [2:0]              mode,
   input  logic                    clamp_en,
   input  logic [2:0]              opsel,
   input  logic [2:0]              opsel_hi,
   input  logic [LANES-1:0]        exec_mask,
   input  logic [LANES*WORD_W-1:0] src_a,
   input  logic [LANES*WORD_W-1:0] src_b,
   input  logic [LANES*WORD_W-1:0] src_c,
   output logic                    out_valid,
   output logic                    out_illegal,
   output logic [LANES*WORD_W-1:0] result
);
   if (LANES < 1) begin : g_bad_lanes
      $error("pk_dot_unit: LANES must be at least 1");
   end

   logic       bad_mode;
   logic       unused_sel2;
   logic [1:0] size_sel;

   assign size_sel    = mode[2:1];
   assign bad_mode    = size_is_bad(size_sel);
   assign unused_sel2 = opsel[2] ^ opsel_hi[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid && bad_mode;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WORD_W-1:0] dot;

      pk_dot_lane u_lane (
         .raw_a    (src_a[l*WORD_W +: WORD_W]),
         .raw_b    (src_b[l*WORD_W +: WORD_W]),
         .acc      (src_c[l*WORD_W +: WORD_W]),
         .size_sel (size_sel),
         .uns      (mode[0]),
         .clamp    (clamp_en),
         .sa_lo    (opsel[0]),
         .sa_hi    (opsel_hi[0]),
         .sb_lo    (opsel[1]),
         .sb_hi    (opsel_hi[1]),
         .dot      (dot)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result[l*WORD_W +: WORD_W] <= '0;
         end else if (in_valid && exec_mask[l]) begin
            result[l*WORD_W +: WORD_W] <= dot;
         end
      end

      assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !(in_valid && exec_mask[l]) |=> $stable(result[l*WORD_W +: WORD_W]));

      assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && exec_mask[l] && mode[2:1] == 2'b11)
            |=> (result[l*WORD_W +: WORD_W] == '0));
   end

   assert_issue_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_flag_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_valid);

   assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[2:1] != 2'b11) |=> !out_illegal);
endmodule

// File: tb/pk_dot_unit_bench.sv
`timescale 1ns/1ps
module pk_dot_unit_bench;
   localparam int LANES = 4;
   localparam int W     = 32;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 in_valid;
   logic [2:0]           mode;
   logic                 clamp_en;
   logic [2:0]           opsel, opsel_hi;
   logic [LANES-1:0]     exec_mask;
   logic [LANES*W-1:0]   src_a, src_b, src_c;
   logic                 out_valid, out_illegal;
   logic [LANES*W-1:0]   result;

   int checks = 0;
   int fails  = 0;

   logic [W-1:0] exp_res [LANES];
   logic         exp_valid;
   logic         exp_illeg;

   always #4 clk = ~clk;

   pk_dot_unit #(.LANES(LANES)) u_pk_dot_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .clamp_en(clamp_en), .opsel(opsel), .opsel_hi(opsel_hi),
      .exec_mask(exec_mask), .src_a(src_a), .src_b(src_b), .src_c(src_c),
      .out_valid(out_valid), .out_illegal(out_illegal), .result(result)
   );

   function automatic logic [W-1:0] ref_dot(input logic [2:0] md, input logic clp,
      input logic [W-1:0] ra, input logic [W-1:0] rb, input logic [W-1:0] c,
      input logic [2:0] os, input logic [2:0] oh);
      logic [W-1:0] wa, wb;
      int n;
      longint lim, sum, ea, eb, p;
      wa = {(oh[0] ? ra[31:16] : ra[15:0]), (os[0] ? ra[31:16] : ra[15:0])};
      wb = {(oh[1] ? rb[31:16] : rb[15:0]), (os[1] ? rb[31:16] : rb[15:0])};
      n = (md[2:1] == 2'd0) ? 16 : (md[2:1] == 2'd1) ? 8 : 4;
      lim = longint'(1) << n;
      sum = longint'(c);
      for (int i = 0; i < 32 / n; i++) begin
         ea = longint'(wa >> (i * n)) & (lim - 1);
         eb = longint'(wb >> (i * n)) & (lim - 1);
         if (!md[0]) begin
            if (ea >= lim / 2) ea = ea - lim;
            if (eb >= lim / 2) eb = eb - lim;
         end
         p = ea * eb;
         if (!md[0]) begin
            if (clp) begin
               if (p > lim / 2 - 1) p = lim / 2 - 1;
               if (p < -(lim / 2))  p = -(lim / 2);
            end
            p = p & (lim - 1);
            if (p >= lim / 2) p = p - lim;
         end else if (clp && p > lim - 1) begin
            p = lim - 1;
         end
         sum = sum + p;
      end
      return sum[31:0];
   endfunction

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check_bit("R8", "out_valid", out_valid, exp_valid);
      check_bit("R9", "out_illegal", out_illegal, exp_illeg);
      for (int l = 0; l < LANES; l++) begin
         checks++;
         if (result[l*W +: W] !== exp_res[l]) begin
            fails++;
            $display("FAIL %s lane %0d: actual %h expected %h", tag, l, result[l*W +: W], exp_res[l]);
         end
      end
   endtask

   // called at a falling edge: drive, update model, wait one cycle, compare
   task automatic issue(input string tag, input logic v, input logic [2:0] md, input logic clp,
      input logic [2:0] os, input logic [2:0] oh, input logic [LANES-1:0] msk,
      input logic [LANES*W-1:0] a, input logic [LANES*W-1:0] b, input logic [LANES*W-1:0] c);
      in_valid = v; mode = md; clamp_en = clp; opsel = os; opsel_hi = oh;
      exec_mask = msk; src_a = a; src_b = b; src_c = c;
      exp_valid = v;
      exp_illeg = v && (md[2:1] == 2'b11);
      for (int l = 0; l < LANES; l++) begin
         if (v && msk[l]) begin
            exp_res[l] = (md[2:1] == 2'b11) ? '0 :
               ref_dot(md, clp, a[l*W +: W], b[l*W +: W], c[l*W +: W], os, oh);
         end
      end
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic [LANES*W-1:0] rep(input logic [W-1:0] x);
      return {LANES{x}};
   endfunction

   function automatic logic [LANES*W-1:0] rnd_vec();
      logic [LANES*W-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*W +: W] = $urandom;
      return v;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; in_valid = 0; mode = 0; clamp_en = 0; opsel = 0; opsel_hi = 0;
      exec_mask = 0; src_a = 0; src_b = 0; src_c = 0;
      for (int l = 0; l < LANES; l++) exp_res[l] = '0;
      exp_valid = 0; exp_illeg = 0;
      repeat (3) @(negedge clk);
      compare("R10");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10");

      // R1 layout, every mode, plain operands
      for (int m = 0; m < 6; m++)
         issue("R1", 1, 3'(m), 0, 3'b010, 3'b011, 4'hF,
               rep(32'h4321_8765), rep(32'h1357_9BDF), rep(32'h0000_0010));
      // R2 signed wrap without clamp and saturation with clamp
      issue("R2", 1, 3'b000, 0, 3'b010, 3'b011, 4'hF, rep(32'h7FFF_7FFF), rep(32'h0002_0002), rep(32'd0));
      issue("R2", 1, 3'b010, 1, 3'b010, 3'b011, 4'hF, rep(32'h8080_8080), rep(32'h8080_8080), rep(32'd5));
      issue("R2", 1, 3'b100, 0, 3'b010, 3'b011, 4'hF, rep(32'h8888_8888), rep(32'h7777_7777), rep(32'd0));
      issue("R2", 1, 3'b100, 1, 3'b010, 3'b011, 4'hF, rep(32'h8888_8888), rep(32'h8888_8888), rep(32'd0));
      // R3 unsigned full products and clamp
      issue("R3", 1, 3'b001, 0, 3'b010, 3'b011, 4'hF, rep(32'hFFFF_FFFF), rep(32'hFFFF_FFFF), rep(32'd7));
      issue("R3", 1, 3'b101, 1, 3'b010, 3'b011, 4'hF, rep(32'hFFFF_FFFF), rep(32'hFFFF_FFFF), rep(32'd0));
      issue("R3", 1, 3'b011, 0, 3'b010, 3'b011, 4'hF, rep(32'hFFFF_FFFF), rep(32'hFFFF_FFFF), rep(32'd0));
      // R4 accumulator wrap
      issue("R4", 1, 3'b011, 0, 3'b010, 3'b011, 4'hF, rep(32'h0000_0001), rep(32'h0000_0003), rep(32'hFFFF_FFFF));
      // R5 / R6 half selects, all combinations
      for (int s = 0; s < 16; s++)
         issue(s < 8 ? "R5" : "R6", 1, 3'b001, 0, {1'b0, 1'(s >> 1), 1'(s)},
               {1'b0, 1'(s >> 3), 1'(s >> 2)}, 4'hF, rep(32'h0003_0005), rep(32'h0007_000B), rep(32'd0));
      // R6 bit 2 has no effect: same operands, bit 2 toggled
      issue("R6", 1, 3'b000, 0, 3'b000, 3'b010, 4'hF, rep(32'h1234_5678), rep(32'h0F0F_7070), rep(32'd1));
      issue("R6", 1, 3'b000, 0, 3'b100, 3'b110, 4'hF, rep(32'h1234_5678), rep(32'h0F0F_7070), rep(32'd1));
      // R7 masked lanes hold, idle cycles hold
      issue("R7", 1, 3'b011, 0, 3'b010, 3'b011, 4'b0101, rnd_vec(), rnd_vec(), rnd_vec());
      issue("R7", 1, 3'b001, 1, 3'b010, 3'b011, 4'b0000, rnd_vec(), rnd_vec(), rnd_vec());
      issue("R7", 0, 3'b000, 0, 3'b010, 3'b011, 4'hF, rnd_vec(), rnd_vec(), rnd_vec());
      // R9 illegal encodings
      issue("R9", 1, 3'b110, 0, 3'b010, 3'b011, 4'b1011, rnd_vec(), rnd_vec(), rnd_vec());
      issue("R9", 1, 3'b111, 1, 3'b010, 3'b011, 4'hF, rnd_vec(), rnd_vec(), rnd_vec());
      issue("R8", 1, 3'b010, 0, 3'b010, 3'b011, 4'hF, rnd_vec(), rnd_vec(), rnd_vec());
      issue("R8", 0, 3'b110, 0, 3'b010, 3'b011, 4'hF, rnd_vec(), rnd_vec(), rnd_vec());

      // random mix over all inputs
      for (int it = 0; it < 400; it++) begin
         logic [2:0] md;
         md = 3'($urandom_range(0, 7));
         issue(md[0] ? "R3" : "R2", 1'($urandom_range(0, 3) != 0), md, 1'($urandom),
               3'($urandom), 3'($urandom), 4'($urandom), rnd_vec(), rnd_vec(), rnd_vec());
      end
      finish_run();
   end
endmodule